// File: doc/BRIEF.md
# Two-Cache Snooping Coherence Controller

This block models a small shared-memory system: two private caches sit on one shared bus in front of one shared memory. Each cache keeps one line per address, so there is no set indexing and no replacement. Each line is invalid, shared or exclusive. Each cache has a processor port that accepts read, write and write-back requests. The bus carries at most one coherence transaction per cycle. Both controllers snoop every transaction, so every coherence event gets one global order.

A mode input selects the write policy at run time. In invalidate mode, a write that needs the bus removes the other cache's copy and leaves the writer exclusive. In update mode, a write broadcasts its value into the other cache's copy and into memory in the same transaction. A request that can complete locally finishes in the cycle it is presented. A request that needs the bus shows busy until the round-robin arbiter grants it. The processor holds a request steady until it sees done.

Top module: `coh_snoop_top`

## Requirements
- R1: After reset every line in both caches is invalid, memory holds zero at every address, and no cache reports busy or done while it has no request.
- R2: A read of a line held shared or exclusive completes in the cycle it is presented. It reports hit=1, returns the cached value and does not use the bus.
- R3: A read of an invalid line is a bus read and reports hit=0. If the other cache holds the line exclusive, that cache supplies the value, memory takes it, and the supplier drops to shared. Otherwise memory supplies the value. The requester's line becomes shared.
- R4: In invalidate mode (mode_upd=0), a write to a line that is not exclusive is a bus write. The other cache's copy becomes invalid, the writer becomes exclusive with the new value, and memory is left unchanged.
- R5: In update mode (mode_upd=1), a write to a line that is not exclusive is a bus write. Memory takes the new value, and so does the other cache's copy if it has one. The writer and the other holder end up shared, so the other cache's next read of that address is a hit.
- R6: A write to a line already held exclusive completes locally in the cycle it is presented, with hit=1. It does so even while the other cache owns the bus for a different address.
- R7: Operation codes 2 and 3 are write-back. On an exclusive line, write-back is a bus transaction that copies the line into memory and leaves it shared. On any other line it completes locally and changes nothing.
- R8: At most one cache is granted the bus per cycle. When both caches need the bus, the one not granted most recently wins, and cache 0 wins the first contest after reset. The loser stays busy until it is granted.
- R9: When the other cache's bus transaction to the same address is granted, a local access to that address waits one cycle. As a result every read returns the value of the most recent write to that address in completion order.
- R10: busy is 1 exactly when a request is present and does not complete in that cycle. done and rdata apply to the request presented in that cycle. Operation codes are 0 read and 1 write.
- R11: An address is never exclusive in one cache while the other cache holds any valid copy of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_upd | input | 1 | 0 selects write-invalidate, 1 selects write-update |
| cpu_req | input | 2 | Request present, one bit per cache |
| cpu_op | input | 2x2 | Operation per cache: 0 read, 1 write, 2 or 3 write-back |
| cpu_addr | input | 2xAW | Address per cache |
| cpu_wdata | input | 2xDW | Write data per cache |
| cpu_busy | output | 2 | Request waiting for the bus |
| cpu_done | output | 2 | Request completes in this cycle |
| cpu_hit | output | 2 | Line was valid when the request completed |
| cpu_rdata | output | 2xDW | Read result, valid with done |

## Verification
The hardest case is a cache doing a local access to an address in the same cycle that the other cache's bus transaction to that address is granted. This covers an exclusive owner writing while the other cache's read miss fetches the line. The bench sets this up by first making one cache the owner and then presenting both requests in the same cycle. It checks that the reader gets the old value and that the writer completes one cycle later through the bus. Long runs of random interleaved requests, with the mode switching back and forth, then compare every read against a reference memory updated in completion order.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    OP_RD = 2'd0,
    OP_WR = 2'd1,
    OP_WB = 2'd2,
    OP_WB2 = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    LN_I = 2'd0,
    LN_S = 2'd1,
    LN_E = 2'd2
  } line_e;

  // header of the single shared bus; address and data travel beside it
  typedef struct packed {
    logic valid;
    logic src;
    op_e  kind;
    logic upd;
    logic owned;
  } bus_hdr_t;

  function automatic logic is_wb(op_e op);
    return (op == OP_WB) || (op == OP_WB2);
  endfunction

  // does a processor request need the bus, given the line state
  function automatic logic needs_bus(op_e op, line_e st);
    case (op)
      OP_RD:   return st == LN_I;
      OP_WR:   return st != LN_E;
      default: return st == LN_E;
    endcase
  endfunction

  // requester's line state after its own granted transaction
  function automatic line_e own_next(op_e op, logic upd);
    if (op == OP_WR) return upd ? LN_S : LN_E;
    return LN_S;
  endfunction

  // snooping cache's line state after the other cache's transaction
  function automatic line_e snoop_next(line_e st, op_e kind, logic upd);
    case (kind)
      OP_RD:   return (st == LN_E) ? LN_S : st;
      OP_WR:   return upd ? ((st == LN_I) ? LN_I : LN_S) : LN_I;
      default: return st;
    endcase
  endfunction

  // round-robin pick between two requesters; last = index granted last
  function automatic logic [1:0] rr_pick(logic [1:0] req, logic last);
    if (req == 2'b11) return last ? 2'b01 : 2'b10;
    return req;
  endfunction

endpackage

// File: rtl/coh_bus_arbiter.sv
module coh_bus_arbiter
  import coh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] need,
  output logic [1:0] grant
);

  logic last_q;

  assign grant = rr_pick(need, last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b1;
    else if (|grant) last_q <= grant[1];
  end

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R8
  grant_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~need) == 2'b00);
  // R8
  rr_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (need == 2'b11 && $past(grant) == 2'b01 && $past(rst_n)) |-> grant == 2'b10);

endmodule

// File: rtl/coh_shared_mem.sv
module coh_shared_mem
  import coh_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned NADDR = 8,
  localparam int unsigned AW   = $clog2(NADDR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_hdr_t      bus_hdr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem_q [NADDR];
  logic          mem_we;

  assign rd_data = mem_q[bus_addr];

  always_comb begin
    mem_we = 1'b0;
    if (bus_hdr.valid) begin
      case (bus_hdr.kind)
        OP_RD:   mem_we = bus_hdr.owned;
        OP_WR:   mem_we = bus_hdr.upd;
        default: mem_we = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NADDR; a++) mem_q[a] <= '0;
    end else if (mem_we) begin
      mem_q[bus_addr] <= bus_data;
    end
  end

  // R4
  mem_hold_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hdr.valid && bus_hdr.kind == OP_WR && !bus_hdr.upd)
      |=> mem_q[$past(bus_addr)] == $past(mem_q[bus_addr]));
  // R5
  mem_take_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hdr.valid && bus_hdr.kind == OP_WR && bus_hdr.upd)
      |=> mem_q[$past(bus_addr)] == $past(bus_data));

endmodule

// File: rtl/coh_cache_ctrl.sv
module coh_cache_ctrl
  import coh_pkg::*;
#(
  parameter int unsigned ID    = 0,
  parameter int unsigned DW    = 8,
  parameter int unsigned NADDR = 8,
  localparam int unsigned AW   = $clog2(NADDR)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic [1:0]            op,
  input  logic [AW-1:0]         addr,
  input  logic [DW-1:0]         wdata,
  input  logic                  grant,
  input  logic                  local_block,
  input  bus_hdr_t              bus_hdr,
  input  logic [AW-1:0]         bus_addr,
  input  logic [DW-1:0]         bus_data,
  output logic                  need_bus,
  output logic [DW-1:0]         req_data,
  output logic                  flush_valid,
  output logic [DW-1:0]         flush_data,
  output logic                  done,
  output logic                  hit,
  output logic [DW-1:0]         rdata,
  output logic [NADDR-1:0][1:0] line_state
);

  line_e         st_q  [NADDR];
  logic [DW-1:0] dat_q [NADDR];

  op_e   cur_op;
  line_e cur_st;
  logic  local_go;
  logic  snoop;
  logic  local_wr;

  assign cur_op   = op_e'(op);
  assign cur_st   = st_q[addr];
  assign need_bus = req && needs_bus(cur_op, cur_st);
  assign local_go = req && !needs_bus(cur_op, cur_st) && !local_block;
  assign local_wr = local_go && (cur_op == OP_WR);
  assign done     = local_go || grant;
  assign hit      = req && (cur_st != LN_I);
  assign rdata    = grant ? bus_data : dat_q[addr];
  assign req_data = (cur_op == OP_WR) ? wdata : dat_q[addr];

  assign flush_valid = (st_q[bus_addr] == LN_E);
  assign flush_data  = dat_q[bus_addr];
  assign snoop       = bus_hdr.valid && (bus_hdr.src != ID[0]);

  always_comb begin
    for (int a = 0; a < NADDR; a++) line_state[a] = st_q[a];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NADDR; a++) begin
        st_q[a]  <= LN_I;
        dat_q[a] <= '0;
      end
    end else begin
      if (grant) begin
        st_q[addr] <= own_next(cur_op, bus_hdr.upd);
        if (!is_wb(cur_op)) dat_q[addr] <= bus_data;
      end else if (local_wr) begin
        dat_q[addr] <= wdata;
      end
      if (snoop) begin
        st_q[bus_addr] <= snoop_next(st_q[bus_addr], bus_hdr.kind, bus_hdr.upd);
        if (bus_hdr.kind == OP_WR && bus_hdr.upd && st_q[bus_addr] != LN_I)
          dat_q[bus_addr] <= bus_data;
      end
    end
  end

  // R3
  fill_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && cur_op == OP_RD) |=> st_q[$past(addr)] == LN_S);
  // R4
  snoop_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop && bus_hdr.kind == OP_WR && !bus_hdr.upd) |=> st_q[$past(bus_addr)] == LN_I);
  // R6
  local_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    local_wr |=> (st_q[$past(addr)] == LN_E && dat_q[$past(addr)] == $past(wdata)));
  // R10
  grant_only_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (req && !local_go));

endmodule

// File: rtl/coh_snoop_top.sv
module coh_snoop_top
  import coh_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned NADDR = 8,
  localparam int unsigned AW   = $clog2(NADDR)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_upd,
  input  logic [1:0]           cpu_req,
  input  logic [1:0][1:0]      cpu_op,
  input  logic [1:0][AW-1:0]   cpu_addr,
  input  logic [1:0][DW-1:0]   cpu_wdata,
  output logic [1:0]           cpu_busy,
  output logic [1:0]           cpu_done,
  output logic [1:0]           cpu_hit,
  output logic [1:0][DW-1:0]   cpu_rdata
);

  localparam int unsigned NC = 2;

  logic [NC-1:0]                  need;
  logic [NC-1:0]                  grant;
  logic [NC-1:0]                  local_block;
  logic [NC-1:0]                  flush_valid;
  logic [NC-1:0][DW-1:0]          flush_data;
  logic [NC-1:0][DW-1:0]          req_data;
  logic [NC-1:0][NADDR-1:0][1:0]  line_state;
  logic                           gsrc;
  bus_hdr_t                       bus_hdr;
  logic [AW-1:0]                  bus_addr;
  logic [DW-1:0]                  bus_data;
  logic [DW-1:0]                  mem_rd;

  coh_bus_arbiter u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .need  (need),
    .grant (grant)
  );

  assign gsrc     = grant[1];
  assign bus_addr = cpu_addr[gsrc];

  always_comb begin
    bus_hdr.valid = |grant;
    bus_hdr.src   = gsrc;
    bus_hdr.kind  = op_e'(cpu_op[gsrc]);
    bus_hdr.upd   = mode_upd;
    bus_hdr.owned = flush_valid[~gsrc];
  end

  assign bus_data = (bus_hdr.kind == OP_RD)
                  ? (flush_valid[~gsrc] ? flush_data[~gsrc] : mem_rd)
                  : req_data[gsrc];

  coh_shared_mem #(.DW(DW), .NADDR(NADDR)) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_hdr  (bus_hdr),
    .bus_addr (bus_addr),
    .bus_data (bus_data),
    .rd_data  (mem_rd)
  );

  for (genvar i = 0; i < NC; i++) begin : g_cache
    assign local_block[i] = grant[NC-1-i] && (bus_addr == cpu_addr[i]);
    assign cpu_busy[i]    = cpu_req[i] && !cpu_done[i];

    coh_cache_ctrl #(.ID(i), .DW(DW), .NADDR(NADDR)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req         (cpu_req[i]),
      .op          (cpu_op[i]),
      .addr        (cpu_addr[i]),
      .wdata       (cpu_wdata[i]),
      .grant       (grant[i]),
      .local_block (local_block[i]),
      .bus_hdr     (bus_hdr),
      .bus_addr    (bus_addr),
      .bus_data    (bus_data),
      .need_bus    (need[i]),
      .req_data    (req_data[i]),
      .flush_valid (flush_valid[i]),
      .flush_data  (flush_data[i]),
      .done        (cpu_done[i]),
      .hit         (cpu_hit[i]),
      .rdata       (cpu_rdata[i]),
      .line_state  (line_state[i])
    );
  end

  for (genvar a = 0; a < NADDR; a++) begin : g_owner
    // R11
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_state[0][a] == LN_E) |-> (line_state[1][a] == LN_I));
    // R11
    single_owner_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_state[1][a] == LN_E) |-> (line_state[0][a] == LN_I));
  end

endmodule

// File: tb/coh_snoop_top_bench.sv
module coh_snoop_top_bench;
  localparam int DW = 8;
  localparam int NADDR = 8;
  localparam int AW = 3;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                mode_upd = 1'b0;
  logic [1:0]          cpu_req = '0;
  logic [1:0][1:0]     cpu_op = '0;
  logic [1:0][AW-1:0]  cpu_addr = '0;
  logic [1:0][DW-1:0]  cpu_wdata = '0;
  logic [1:0]          cpu_busy, cpu_done, cpu_hit;
  logic [1:0][DW-1:0]  cpu_rdata;

  int checks = 0;
  int fails = 0;
  int ref_mem [NADDR];

  always #2 clk = ~clk;

  coh_snoop_top #(.DW(DW), .NADDR(NADDR)) u_coh_snoop_top (
    .clk(clk), .rst_n(rst_n), .mode_upd(mode_upd), .cpu_req(cpu_req),
    .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_hit(cpu_hit),
    .cpu_rdata(cpu_rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference memory: reads see the value before this cycle's writes
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 2; i++) begin
        chk(cpu_busy[i] == (cpu_req[i] && !cpu_done[i]), "R10 busy", cpu_busy[i], cpu_req[i] && !cpu_done[i]);
        if (cpu_req[i] && cpu_done[i] && cpu_op[i] == 2'd0)
          chk(int'(cpu_rdata[i]) == ref_mem[cpu_addr[i]], "R9 read value", cpu_rdata[i], ref_mem[cpu_addr[i]]);
      end
      for (int i = 0; i < 2; i++)
        if (cpu_req[i] && cpu_done[i] && cpu_op[i] == 2'd1)
          ref_mem[cpu_addr[i]] = int'(cpu_wdata[i]);
    end
  end

  task automatic set_req(input int i, input int op, input int a, input int d);
    cpu_req[i] = 1'b1; cpu_op[i] = op[1:0]; cpu_addr[i] = a[AW-1:0]; cpu_wdata[i] = d[DW-1:0];
  endtask

  task automatic adv();
    @(posedge clk); #1;
  endtask

  // single request on cache i; expects completion in the presented cycle
  task automatic solo(input int i, input int op, input int a, input int d,
                      input int exp_hit, input int exp_rd, input string tag);
    cpu_req = '0;
    set_req(i, op, a, d);
    @(negedge clk);
    chk(cpu_done[i] == 1'b1, {tag, " done"}, cpu_done[i], 1);
    chk(int'(cpu_hit[i]) == exp_hit, {tag, " hit"}, cpu_hit[i], exp_hit);
    if (op == 0) chk(int'(cpu_rdata[i]) == exp_rd, {tag, " data"}, cpu_rdata[i], exp_rd);
    adv();
    cpu_req = '0;
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit [1:0] seen;
    for (int a = 0; a < NADDR; a++) ref_mem[a] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_busy == 2'b00 && cpu_done == 2'b00, "R1 idle after reset", {cpu_busy, cpu_done}, 0);
    adv();

    // invalidate-mode trace on address 1
    mode_upd = 1'b0;
    solo(0, 0, 1, 0, 0, 0, "R1 R3 A read miss");
    solo(1, 0, 1, 0, 0, 0, "R3 B read miss");
    solo(0, 1, 1, 1, 1, 0, "R4 A write");
    solo(1, 0, 1, 0, 0, 1, "R4 R3 B miss after inval");
    solo(0, 0, 1, 0, 1, 1, "R2 A read hit");

    // update-mode trace on address 2
    mode_upd = 1'b1;
    solo(0, 0, 2, 0, 0, 0, "R3 A read");
    solo(1, 0, 2, 0, 0, 0, "R3 B read");
    solo(0, 1, 2, 5, 1, 0, "R5 A write");
    solo(1, 0, 2, 0, 1, 5, "R5 B read hit");

    // write-back on address 3
    mode_upd = 1'b0;
    solo(0, 1, 3, 9, 0, 0, "R4 A write miss");
    solo(0, 2, 3, 0, 1, 0, "R7 A writeback");
    solo(0, 3, 3, 0, 1, 0, "R7 A writeback shared");
    solo(1, 0, 3, 0, 0, 9, "R7 B read from memory");

    // exclusive write while the other cache holds the bus
    solo(0, 1, 0, 4, 0, 0, "R4 A own addr0");
    cpu_req = '0;
    set_req(0, 1, 0, 7);
    set_req(1, 1, 2, 6);
    @(negedge clk);
    chk(cpu_done == 2'b11, "R6 local write beside bus", cpu_done, 3);
    chk(cpu_hit[0] == 1'b1, "R6 hit", cpu_hit[0], 1);
    adv();
    cpu_req = '0;

    // round robin: last grant was cache 1, so cache 0 wins
    set_req(0, 0, 4, 0);
    set_req(1, 0, 5, 0);
    @(negedge clk);
    chk(cpu_done == 2'b01, "R8 first contest", cpu_done, 1);
    chk(cpu_busy == 2'b10, "R8 loser busy", cpu_busy, 2);
    adv();
    cpu_req[0] = 1'b0;
    @(negedge clk);
    chk(cpu_done[1] == 1'b1, "R8 loser granted", cpu_done[1], 1);
    adv();
    cpu_req = '0;
    solo(0, 1, 4, 3, 1, 0, "R8 A alone on bus");
    set_req(0, 0, 6, 0);
    set_req(1, 0, 7, 0);
    @(negedge clk);
    chk(cpu_done == 2'b10, "R8 rotation", cpu_done, 2);
    adv();
    cpu_req[1] = 1'b0;
    @(negedge clk);
    chk(cpu_done[0] == 1'b1, "R8 second granted", cpu_done[0], 1);
    adv();
    cpu_req = '0;

    // same-address race: A exclusive on addr0 (value 7)
    set_req(0, 1, 0, 8);
    set_req(1, 0, 0, 0);
    @(negedge clk);
    chk(cpu_done == 2'b10, "R9 local held off", cpu_done, 2);
    chk(int'(cpu_rdata[1]) == 7, "R9 reader gets old", cpu_rdata[1], 7);
    adv();
    cpu_req[1] = 1'b0;
    @(negedge clk);
    chk(cpu_done[0] == 1'b1, "R9 writer via bus", cpu_done[0], 1);
    adv();
    cpu_req = '0;
    solo(1, 0, 0, 0, 0, 8, "R9 B sees new value");

    // random interleaved traffic in both modes
    seen = 2'b11;
    for (int c = 0; c < 6000; c++) begin
      if (c % 97 == 0) mode_upd = ~mode_upd;
      for (int i = 0; i < 2; i++) begin
        if (seen[i] || !cpu_req[i]) begin
          if ($urandom_range(0, 3) == 0) cpu_req[i] = 1'b0;
          else set_req(i, $urandom_range(0, 3), $urandom_range(0, NADDR - 1), $urandom_range(0, 255));
        end
      end
      @(negedge clk);
      seen = cpu_done & cpu_req;
      adv();
    end
    cpu_req = '0;
    adv();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule